// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block stores the state that a physical memory protection unit works from. For each of `N_ENT` protection entries it keeps an 8-bit configuration byte and an `XLEN`-wide address register. It also keeps one 3-bit security configuration register. Software reaches these through a CSR-style port: a write strobe, a read strobe, a register-kind selector, an index and `XLEN`-wide data. Configuration bytes are packed several to a CSR. Reads are combinational and return zero unless the read strobe is high.

Every write passes through the lock policy before it reaches storage. A write that the policy refuses is dropped without any indication. Two lock policies exist, and the parameter `ENHANCED` picks one of them. The plain policy respects only the per-entry lock bit. The enhanced policy adds a rule-lock bypass, a machine-mode lockdown with its own exceptions, and sticky security bits. The address-register locking rules, including the lock held by the following entry in top-of-range mode, apply under both policies.

The stored bytes go out flat, together with the lock, mode and permission fields broken out per entry, for the range decoders and access checkers downstream. Reset is asynchronous and active low. Its release is synchronised inside the block. Register kinds on `csr_kind` are: 0 configuration, 1 address, 2 security, 3 unused.

Top module: `pmp_cfg_regfile`

## Requirements
- R1: While reset is asserted and directly after it, every configuration byte, address register and security bit is zero.
- R2: A configuration write with index k places data byte i (bits 8i+7:8i) in entry 4k+i, for every byte of the XLEN-wide word. A configuration read returns the same bytes concatenated in the same order. Byte positions for entries at or above `N_ENT` read as zero, and writes to them are discarded. Byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (2'b01 top-of-range), bit 7 lock.
- R3: When XLEN is 64, a configuration write with an odd index changes no entry.
- R4: With `ENHANCED`=0, a configuration write to an entry whose lock bit is set is discarded for that entry.
- R5: With `ENHANCED`=1, a configuration write to an entry is accepted only in four cases. The first is that the security bypass bit is set. The second is that lockdown is clear and the entry is unlocked. The third is that lockdown is set and the new byte has lock set and execute clear. The fourth is that lockdown is set and the new byte has lock clear and bits 2:0 not equal to 3'b110. Any other configuration write is discarded.
- R6: An address write to entry j is discarded when entry j is locked. It is also discarded when entry j+1 exists, is locked, and has mode top-of-range. An address index at or above `N_ENT` reads zero and changes nothing.
- R7: The security register holds bit 0 lockdown, bit 1 whitelist policy and bit 2 rule-lock bypass. A write cannot set the bypass bit while it is currently 0 and any entry is locked.
- R8: Once the lockdown bit or the whitelist bit is 1, it stays 1 until reset, whatever is written.
- R9: `entry_lock`, `entry_mode` and `entry_perm` show bit 7, bits 4:3 and bits 2:0 of each stored byte. `csr_rdata` is zero when `csr_re` is low or `csr_kind` is 3.
- R10: An accepted address write stores all XLEN bits, and a read of that index returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_kind | input | 2 | Register kind: 0 config, 1 address, 2 security |
| csr_idx | input | IDX_W | CSR index within the kind |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| cfg_flat | output | 8*N_ENT | All configuration bytes, entry e at bits 8e+7:8e |
| addr_flat | output | XLEN*N_ENT | All address registers |
| entry_lock | output | N_ENT | Lock bit per entry |
| entry_mode | output | 2*N_ENT | Match-mode field per entry |
| entry_perm | output | 3*N_ENT | Execute, write and read bits per entry |
| sec_lockdown | output | 1 | Machine-mode lockdown bit |
| sec_whitelist | output | 1 | Whitelist-policy bit |
| sec_bypass | output | 1 | Rule-lock bypass bit |

## Verification
Storage is visible on the flat outputs from the cycle after a write. A wrongly accepted or wrongly dropped write therefore shows up as a byte or address mismatch one clock after the write that caused it. A wrong lane mapping shows up in the same way, and so does a security bit that leaks out of its sticky state. Read-path faults appear on `csr_rdata` during the write's own cycle, because the read is combinational. Three configurations run side by side on the same stimulus: enhanced at 32 bits, plain at 32 bits, and enhanced at 64 bits. Each is compared against a behavioural model after every write.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;
  // configuration byte fields
  localparam int CB_R    = 0;
  localparam int CB_W    = 1;
  localparam int CB_X    = 2;
  localparam int CB_MLO  = 3;
  localparam int CB_L    = 7;
  localparam logic [1:0] MODE_TOR = 2'b01;

  // security register fields
  localparam int SEC_MML  = 0;
  localparam int SEC_MMWP = 1;
  localparam int SEC_RLB  = 2;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csr_kind_e;
endpackage

// File: rtl/pmp_entry_regs.sv
module pmp_entry_regs
  import pmp_cfg_pkg::*;
#(
  parameter int  XLEN     = 32,
  parameter bit  ENHANCED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wdata,
  input  logic            nxt_tor_locked,
  input  logic            sec_mml,
  input  logic            sec_rlb,
  output logic [7:0]      cfg_q,
  output logic [XLEN-1:0] addr_q
);
  logic       plain_ok, enh_ok, cfg_ok, addr_ok;
  logic [7:0] cfg_d;
  logic [XLEN-1:0] addr_d;

  always_comb begin
    plain_ok = !cfg_q[CB_L];
    enh_ok   = sec_rlb
            || (!sec_mml && !cfg_q[CB_L])
            || (sec_mml && cfg_wdata[CB_L] && !cfg_wdata[CB_X])
            || (sec_mml && !cfg_wdata[CB_L] && (cfg_wdata[2:0] != 3'b110));
    cfg_ok   = cfg_we && (ENHANCED ? enh_ok : plain_ok);
    addr_ok  = addr_we && !cfg_q[CB_L] && !nxt_tor_locked;
    cfg_d    = cfg_ok  ? cfg_wdata  : cfg_q;
    addr_d   = addr_ok ? addr_wdata : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_ok)  cfg_q  <= cfg_d;
      if (addr_ok) addr_q <= addr_d;
    end
  end

  // R6
  addr_self_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && cfg_q[CB_L]) |=> $stable(addr_q));

  // R6
  addr_next_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && nxt_tor_locked) |=> $stable(addr_q));

  generate
    if (ENHANCED) begin : g_enh_chk
      // R5
      lockdown_exec_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && sec_mml && !sec_rlb && cfg_wdata[CB_L] && cfg_wdata[CB_X])
        |=> $stable(cfg_q));
    end else begin : g_plain_chk
      // R4
      plain_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_q[CB_L]) |=> $stable(cfg_q));
    end
  endgenerate
endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmp_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wdata,
  input  logic       any_lock,
  output logic [2:0] sec_q
);
  logic [2:0] sec_d;

  always_comb begin
    sec_d = sec_q;
    if (we) begin
      sec_d = wdata;
      if (!sec_q[SEC_RLB] && any_lock) sec_d[SEC_RLB] = 1'b0;
      sec_d[SEC_MML]  = sec_d[SEC_MML]  | sec_q[SEC_MML];
      sec_d[SEC_MMWP] = sec_d[SEC_MMWP] | sec_q[SEC_MMWP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sec_q <= '0;
    else if (we) sec_q <= sec_d;
  end

  // R8
  sticky_lockdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[SEC_MML] |=> sec_q[SEC_MML]);

  // R8
  sticky_whitelist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[SEC_MMWP] |=> sec_q[SEC_MMWP]);

  // R7
  bypass_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sec_q[SEC_RLB] && any_lock) |=> !sec_q[SEC_RLB]);
endmodule

// File: rtl/pmp_cfg_regfile.sv
module pmp_cfg_regfile
  import pmp_cfg_pkg::*;
#(
  parameter int N_ENT    = 16,
  parameter int XLEN     = 32,
  parameter int IDX_W    = 6,
  parameter bit ENHANCED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_we,
  input  logic                  csr_re,
  input  logic [1:0]            csr_kind,
  input  logic [IDX_W-1:0]      csr_idx,
  input  logic [XLEN-1:0]       csr_wdata,
  output logic [XLEN-1:0]       csr_rdata,
  output logic [8*N_ENT-1:0]    cfg_flat,
  output logic [XLEN*N_ENT-1:0] addr_flat,
  output logic [N_ENT-1:0]      entry_lock,
  output logic [2*N_ENT-1:0]    entry_mode,
  output logic [3*N_ENT-1:0]    entry_perm,
  output logic                  sec_lockdown,
  output logic                  sec_whitelist,
  output logic                  sec_bypass
);
  localparam int BYTES   = XLEN / 8;
  localparam int ENT_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int BW      = IDX_W + 2;
  localparam bit ODD_GAP = (XLEN == 64);
  localparam logic [BW-1:0] BYTES_V = BW'(BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [7:0]      cfg_arr  [N_ENT];
  logic [XLEN-1:0] addr_arr [N_ENT];
  logic [N_ENT-1:0] lock_vec;
  logic [2:0]      sec_q;
  logic [BW-1:0]   base;
  logic            cfg_wr_ok, addr_wr, sec_wr;

  assign base      = {csr_idx, 2'b00};
  assign cfg_wr_ok = csr_we && (csr_kind == KIND_CFG) && !(ODD_GAP && csr_idx[0]);
  assign addr_wr   = csr_we && (csr_kind == KIND_ADDR);
  assign sec_wr    = csr_we && (csr_kind == KIND_SEC);

  generate
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      localparam logic [BW-1:0] EV = BW'(e);
      logic [BW-1:0] lane;
      logic          lane_hit, nxt_tor;
      logic [7:0]    lane_byte;

      assign lane     = EV - base;
      assign lane_hit = cfg_wr_ok && (EV >= base) && (lane < BYTES_V);

      always_comb begin
        lane_byte = '0;
        for (int b = 0; b < BYTES; b++)
          if (lane == BW'(b)) lane_byte = csr_wdata[b*8 +: 8];
      end

      if (e + 1 < N_ENT) begin : g_nxt
        assign nxt_tor = cfg_arr[e+1][CB_L] && (cfg_arr[e+1][CB_MLO +: 2] == MODE_TOR);
      end else begin : g_last
        assign nxt_tor = 1'b0;
      end

      pmp_entry_regs #(.XLEN(XLEN), .ENHANCED(ENHANCED)) u_ent (
        .clk            (clk),
        .rst_n          (rst_int_n),
        .cfg_we         (lane_hit),
        .cfg_wdata      (lane_byte),
        .addr_we        (addr_wr && (csr_idx == IDX_W'(e))),
        .addr_wdata     (csr_wdata),
        .nxt_tor_locked (nxt_tor),
        .sec_mml        (sec_q[SEC_MML]),
        .sec_rlb        (sec_q[SEC_RLB]),
        .cfg_q          (cfg_arr[e]),
        .addr_q         (addr_arr[e])
      );

      assign lock_vec[e]                 = cfg_arr[e][CB_L];
      assign cfg_flat[e*8 +: 8]          = cfg_arr[e];
      assign addr_flat[e*XLEN +: XLEN]   = addr_arr[e];
      assign entry_lock[e]               = cfg_arr[e][CB_L];
      assign entry_mode[e*2 +: 2]        = cfg_arr[e][CB_MLO +: 2];
      assign entry_perm[e*3 +: 3]        = cfg_arr[e][CB_X:CB_R];
    end
  endgenerate

  pmp_sec_reg u_sec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (sec_wr),
    .wdata    (csr_wdata[2:0]),
    .any_lock (|lock_vec),
    .sec_q    (sec_q)
  );

  assign sec_lockdown  = sec_q[SEC_MML];
  assign sec_whitelist = sec_q[SEC_MMWP];
  assign sec_bypass    = sec_q[SEC_RLB];

  always_comb begin
    csr_rdata = '0;
    if (csr_re) begin
      case (csr_kind)
        KIND_CFG: begin
          for (int b = 0; b < BYTES; b++) begin
            int ent;
            ent = int'(base) + b;
            if (ent < N_ENT) csr_rdata[b*8 +: 8] = cfg_arr[ent];
          end
        end
        KIND_ADDR: if (int'(csr_idx) < N_ENT) csr_rdata = addr_arr[csr_idx[ENT_W-1:0]];
        KIND_SEC:  csr_rdata[2:0] = sec_q;
        default:   csr_rdata = '0;
      endcase
    end
  end

  generate
    if (ODD_GAP) begin : g_odd_chk
      // R3
      odd_cfg_index_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (csr_we && (csr_kind == KIND_CFG) && csr_idx[0]) |=> $stable(cfg_flat));
    end
  endgenerate

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !csr_re |-> (csr_rdata == '0));
endmodule

// File: tb/pmp_cfg_regfile_tb_top.sv
module pmp_cfg_regfile_tb_top;
  localparam int N  = 16;
  localparam int IW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        we, re;
  logic [1:0]  kind;
  logic [IW-1:0] idx;
  logic [63:0] wd;

  logic [31:0] rd_a, rd_b;
  logic [63:0] rd_c;
  logic [N*8-1:0]  cf_a, cf_b, cf_c;
  logic [N*32-1:0] ad_a, ad_b;
  logic [N*64-1:0] ad_c;
  logic [N-1:0]    lk_a, lk_b, lk_c;
  logic [2*N-1:0]  md_a, md_b, md_c;
  logic [3*N-1:0]  pm_a, pm_b, pm_c;
  logic [2:0]      sc_a, sc_b, sc_c;

  pmp_cfg_regfile #(.N_ENT(N), .XLEN(32), .IDX_W(IW), .ENHANCED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_re(re), .csr_kind(kind), .csr_idx(idx),
    .csr_wdata(wd[31:0]), .csr_rdata(rd_a), .cfg_flat(cf_a), .addr_flat(ad_a),
    .entry_lock(lk_a), .entry_mode(md_a), .entry_perm(pm_a),
    .sec_lockdown(sc_a[0]), .sec_whitelist(sc_a[1]), .sec_bypass(sc_a[2]));

  pmp_cfg_regfile #(.N_ENT(N), .XLEN(32), .IDX_W(IW), .ENHANCED(1'b0)) dut_plain_i (
    .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_re(re), .csr_kind(kind), .csr_idx(idx),
    .csr_wdata(wd[31:0]), .csr_rdata(rd_b), .cfg_flat(cf_b), .addr_flat(ad_b),
    .entry_lock(lk_b), .entry_mode(md_b), .entry_perm(pm_b),
    .sec_lockdown(sc_b[0]), .sec_whitelist(sc_b[1]), .sec_bypass(sc_b[2]));

  pmp_cfg_regfile #(.N_ENT(N), .XLEN(64), .IDX_W(IW), .ENHANCED(1'b1)) dut_wide_i (
    .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_re(re), .csr_kind(kind), .csr_idx(idx),
    .csr_wdata(wd), .csr_rdata(rd_c), .cfg_flat(cf_c), .addr_flat(ad_c),
    .entry_lock(lk_c), .entry_mode(md_c), .entry_perm(pm_c),
    .sec_lockdown(sc_c[0]), .sec_whitelist(sc_c[1]), .sec_bypass(sc_c[2]));

  // behavioural model: 0 = enhanced/32, 1 = plain/32, 2 = enhanced/64
  int          xl [3] = '{32, 32, 64};
  bit          en [3] = '{1'b1, 1'b0, 1'b1};
  logic [7:0]  m_cfg  [3][N];
  logic [63:0] m_addr [3][N];
  logic [2:0]  m_sec  [3];

  int total = 0;
  int bad   = 0;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic m_reset();
    for (int k = 0; k < 3; k++) begin
      m_sec[k] = '0;
      for (int e = 0; e < N; e++) begin
        m_cfg[k][e] = '0;
        m_addr[k][e] = '0;
      end
    end
  endtask

  function automatic logic [63:0] m_read(int k, logic [1:0] kd, int i);
    logic [63:0] r = '0;
    if (kd == 2'd0) begin
      for (int b = 0; b < xl[k] / 8; b++)
        if (i * 4 + b < N) r[b*8 +: 8] = m_cfg[k][i*4+b];
    end else if (kd == 2'd1) begin
      if (i < N) r = m_addr[k][i];
    end else if (kd == 2'd2) begin
      r[2:0] = m_sec[k];
    end
    return r;
  endfunction

  task automatic m_apply(int k, logic [1:0] kd, int i, logic [63:0] d);
    if (kd == 2'd0) begin
      if (!(xl[k] == 64 && (i % 2) == 1)) begin
        for (int b = 0; b < xl[k] / 8; b++) begin
          int e = i * 4 + b;
          if (e < N) begin
            logic [7:0] nb = d[b*8 +: 8];
            logic [7:0] cur = m_cfg[k][e];
            bit mml = m_sec[k][0];
            bit acc;
            if (en[k])
              acc = m_sec[k][2] || (!mml && !cur[7]) || (mml && nb[7] && !nb[2])
                 || (mml && !nb[7] && nb[2:0] != 3'b110);
            else
              acc = !cur[7];
            if (acc) m_cfg[k][e] = nb;
          end
        end
      end
    end else if (kd == 2'd1) begin
      if (i < N) begin
        bit blk = m_cfg[k][i][7];
        if (i + 1 < N && m_cfg[k][i+1][7] && m_cfg[k][i+1][4:3] == 2'b01) blk = 1'b1;
        if (!blk) m_addr[k][i] = (xl[k] == 32) ? {32'd0, d[31:0]} : d;
      end
    end else if (kd == 2'd2) begin
      logic [2:0] nv = d[2:0];
      bit any_l = 1'b0;
      for (int e = 0; e < N; e++) if (m_cfg[k][e][7]) any_l = 1'b1;
      if (!m_sec[k][2] && any_l) nv[2] = 1'b0;
      nv[1:0] = nv[1:0] | m_sec[k][1:0];
      m_sec[k] = nv;
    end
  endtask

  function automatic logic [63:0] got_rd(int k);
    return (k == 0) ? {32'd0, rd_a} : (k == 1) ? {32'd0, rd_b} : rd_c;
  endfunction
  function automatic logic [7:0] got_cfg(int k, int e);
    return (k == 0) ? cf_a[e*8 +: 8] : (k == 1) ? cf_b[e*8 +: 8] : cf_c[e*8 +: 8];
  endfunction
  function automatic logic [63:0] got_addr(int k, int e);
    return (k == 0) ? {32'd0, ad_a[e*32 +: 32]} : (k == 1) ? {32'd0, ad_b[e*32 +: 32]}
                    : ad_c[e*64 +: 64];
  endfunction
  function automatic logic [2:0] got_sec(int k);
    return (k == 0) ? sc_a : (k == 1) ? sc_b : sc_c;
  endfunction

  task automatic compare_state(string tag);
    for (int k = 0; k < 3; k++) begin
      for (int e = 0; e < N; e++) begin
        chk(tag, $sformatf("cfg[%0d] inst%0d", e, k), 64'(got_cfg(k, e)), 64'(m_cfg[k][e]));
        chk(tag, $sformatf("addr[%0d] inst%0d", e, k), got_addr(k, e), m_addr[k][e]);
      end
      chk(tag, $sformatf("sec inst%0d", k), 64'(got_sec(k)), 64'(m_sec[k]));
    end
    // R9 decoded fields on the enhanced 32-bit instance
    for (int e = 0; e < N; e++) begin
      chk("R9", $sformatf("lock[%0d]", e), 64'(lk_a[e]), 64'(m_cfg[0][e][7]));
      chk("R9", $sformatf("mode[%0d]", e), 64'(md_a[e*2 +: 2]), 64'(m_cfg[0][e][4:3]));
      chk("R9", $sformatf("perm[%0d]", e), 64'(pm_a[e*3 +: 3]), 64'(m_cfg[0][e][2:0]));
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(bit w, bit r, logic [1:0] kd, int i, logic [63:0] d, string tag);
    we = w; re = r; kind = kd; idx = IW'(i); wd = d;
    #1;
    for (int k = 0; k < 3; k++)
      chk(tag, $sformatf("rdata inst%0d", k), got_rd(k), r ? m_read(k, kd, i) : 64'd0);
    @(posedge clk);
    if (w) for (int k = 0; k < 3; k++) m_apply(k, kd, i, d);
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    compare_state(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    we = 1'b0; re = 1'b0; kind = 2'd0; idx = '0; wd = '0;
    m_reset();
    repeat (3) @(negedge clk);
    compare_state("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_state("R1");
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R2 packing, reads, out-of-range lanes
    step(1, 1, 2'd0, 0, 64'h1122_3344_0B1A_0903, "R2");
    step(0, 1, 2'd0, 0, 64'd0, "R2");
    step(1, 1, 2'd0, 4, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    step(0, 1, 2'd0, 4, 64'd0, "R2");
    // R3 odd index: ignored at 64 bits only
    step(1, 0, 2'd0, 1, 64'h5566_7788_0102_0304, "R3");
    step(0, 1, 2'd0, 1, 64'd0, "R3");
    // R10 full-width address storage
    for (int j = 0; j < 4; j++)
      step(1, 1, 2'd1, j, 64'hA5A5_0000_C3C3_0000 + 64'(j), "R10");
    step(0, 1, 2'd1, 2, 64'd0, "R10");
    step(1, 1, 2'd1, 20, 64'h1234, "R6");
    // lock entry 1 in top-of-range mode
    step(1, 0, 2'd0, 0, 64'h0000_0000_0000_8803, "R5");
    step(1, 0, 2'd1, 0, 64'hDEAD, "R6");
    step(1, 0, 2'd1, 1, 64'hBEEF, "R6");
    step(1, 0, 2'd1, 2, 64'hCAFE, "R6");
    // locked entry rewrite: dropped by both policies
    step(1, 0, 2'd0, 0, 64'h0000_0000_0000_0107, "R4");
    // bypass cannot be set while an entry is locked
    step(1, 1, 2'd2, 0, 64'h4, "R7");
    step(0, 1, 2'd2, 0, 64'h0, "R7");

    // bypass path
    do_reset();
    step(1, 0, 2'd2, 0, 64'h4, "R7");
    step(1, 0, 2'd0, 0, 64'h0000_0000_0000_8100, "R5");
    step(1, 0, 2'd0, 0, 64'h0000_0000_0000_0300, "R5");
    step(1, 0, 2'd2, 0, 64'h0, "R7");
    step(1, 0, 2'd2, 0, 64'h4, "R7");

    // lockdown exceptions
    do_reset();
    step(1, 1, 2'd2, 0, 64'h1, "R8");
    step(1, 1, 2'd2, 0, 64'h0, "R8");
    step(1, 0, 2'd0, 0, 64'h0000_0000_8681_0603, "R5");
    step(1, 0, 2'd0, 0, 64'h0000_0000_0000_0085, "R5");
    step(1, 0, 2'd2, 0, 64'h2, "R8");
    step(1, 1, 2'd2, 0, 64'h0, "R8");
    step(0, 1, 2'd3, 0, 64'h0, "R9");
    step(1, 0, 2'd3, 0, 64'hFFFF, "R9");

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      for (int n = 0; n < 400; n++) begin
        logic [1:0] kd = 2'($urandom % 4);
        int i = (kd == 2'd0) ? int'($urandom % 6) : int'($urandom % 20);
        logic [63:0] d = {$urandom, $urandom};
        if (kd == 2'd2 && ($urandom % 4) != 0) d[0] = 1'b0;
        step(($urandom % 4) != 0, ($urandom % 2) == 1, kd, i, d, "R5");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule